// File: doc/BRIEF.md
# Oscillator Band-Select Calibration Sequencer

This block runs the automatic calibration of a wide-range oscillator whose tuning range is split into overlapping bands. A small register write port configures the synthesizer. Writing the calibration-trigger register starts a search, so that register is meant to be written after all the others. Writes to any other address only store data.

Once started, the block parks the oscillator tuning node on an internal reference voltage. It then runs a successive-approximation search over the band code, using a comparator that reports whether the feedback clock runs faster than the reference clock. The search takes one step per phase-detector tick. After the last band bit, one more tick latches the result. At that point the amplitude code goes to midscale and the half-step divider setting is applied. The divider setting is a snapshot of the configuration register taken at the trigger. The tuning node then returns to loop control.

Because the bands overlap, several codes can cover one frequency. The search settles on the highest band whose frequency does not exceed the target, as the comparator reports it. The result holds until the next trigger.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, busy, tune_park, band_code, div_code and amp_code are all zero.
- R2: A write to address 3 makes busy and tune_park high on the next cycle, and band_code shows the first trial value 4'b1000.
- R3: A write to any address other than 3 does not start a calibration; busy stays low.
- R4: A calibration consumes exactly 5 PFD ticks. busy and tune_park are high together from the cycle after the trigger until the cycle after the fifth tick.
- R5: The search is MSB first, one band bit per tick. On each of the first four ticks, a high comparator input (feedback faster) clears the bit under test and the next lower bit is set. With a comparator that is high exactly when band_code exceeds a target T, the result equals T for every T from 0 to 15.
- R6: When the result latches, amp_code becomes midscale (4'd8).
- R7: div_code selects the divide ratio 2 + code/2. It is taken from bits of the address-1 register captured at the trigger, with any stored value above 12 clamped to 12. It changes only when the result latches.
- R8: A write to address 3 during a calibration restarts it. band_code returns to 4'b1000, and 5 further ticks are needed to finish.
- R9: A write to address 1 during a calibration is stored at once but does not change that calibration's div_code. The next trigger uses the new value.
- R10: While idle, band_code, div_code and amp_code hold their values whatever the comparator does.
- R11: PFD ticks arriving while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| pfd_tick | input | 1 | One-cycle pulse at the phase-detector rate |
| fb_fast | input | 1 | Comparator: feedback clock faster than reference |
| band_code | output | 4 | Oscillator band drive (trial value during search, result afterwards) |
| div_code | output | 4 | Half-step divider setting |
| amp_code | output | 4 | Oscillator amplitude setting |
| tune_park | output | 1 | High: tuning node tied to the internal reference |
| busy | output | 1 | Calibration in progress |

## Verification
The hardest situation to reach is a second trigger, or a divider-register write, that arrives part way through a search. These can only come from the write port, at a known point relative to the PFD tick stream. The bench counts the ticks consumed while busy is high and issues the interfering write after exactly two of them. It then checks the trial code right after the restart and counts the five ticks again. A bench model of the oscillator drives the comparator from the live band code against a chosen target, so each finished search shows its whole bit decision chain as a single value.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    // Default geometry shared by the sequencer modules
    localparam int unsigned VBC_BAND_W  = 4;
    localparam int unsigned VBC_DIV_W   = 4;
    localparam int unsigned VBC_DIV_MAX = 12;
    localparam int unsigned VBC_AMP_W   = 4;
    localparam int unsigned VBC_ADDR_W  = 2;
    localparam int unsigned VBC_DATA_W  = 8;
endpackage

// File: rtl/vbc_cfg_port.sv
module vbc_cfg_port #(
    parameter int unsigned ADDR_W    = vbc_pkg::VBC_ADDR_W,
    parameter int unsigned DATA_W    = vbc_pkg::VBC_DATA_W,
    parameter int unsigned TRIG_ADDR = 3,
    parameter int unsigned DIV_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              trig,
    output logic [DATA_W-1:0] div_cfg
);
    logic [DATA_W-1:0] div_cfg_d, div_cfg_q;

    always_comb begin
        div_cfg_d = div_cfg_q;
        if (wr_en && wr_addr == ADDR_W'(DIV_ADDR))
            div_cfg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cfg_q <= '0;
        else        div_cfg_q <= div_cfg_d;
    end

    assign trig    = wr_en && (wr_addr == ADDR_W'(TRIG_ADDR));
    assign div_cfg = div_cfg_q;

    // R9: a divider-register write is visible on the next cycle
    assert_cfg_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(DIV_ADDR)) |=> div_cfg == $past(wr_data));
endmodule

// File: rtl/vbc_sar.sv
module vbc_sar #(
    parameter int unsigned BAND_W = vbc_pkg::VBC_BAND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              fb_fast,
    output logic              active,
    output logic              done,
    output logic [BAND_W-1:0] trial
);
    localparam int unsigned STEP_W = $clog2(BAND_W + 1);
    localparam logic [BAND_W-1:0] MSB_MASK = {1'b1, {(BAND_W-1){1'b0}}};

    typedef struct packed {
        logic              active;
        logic [STEP_W-1:0] step;
        logic [BAND_W-1:0] trial;
    } sar_t;

    sar_t sar_d, sar_q;
    logic [BAND_W-1:0] cur_mask;
    logic              last_step;

    always_comb begin
        sar_d     = sar_q;
        cur_mask  = MSB_MASK >> sar_q.step;
        last_step = (sar_q.step == STEP_W'(BAND_W));
        done      = sar_q.active && tick && last_step && !start;
        if (start) begin
            sar_d.active = 1'b1;
            sar_d.step   = '0;
            sar_d.trial  = MSB_MASK;
        end else if (sar_q.active && tick) begin
            if (last_step) begin
                sar_d.active = 1'b0;
            end else begin
                if (fb_fast)
                    sar_d.trial = sar_d.trial & ~cur_mask;
                sar_d.trial = sar_d.trial | (cur_mask >> 1);
                sar_d.step  = sar_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sar_q <= '0;
        else        sar_q <= sar_d;
    end

    assign active = sar_q.active;
    assign trial  = sar_q.trial;

    // R2 / R8: every trigger (first or repeated) begins at the MSB trial
    assert_start_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && trial == MSB_MASK));
    // R11: idle ticks leave the search state alone
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> (!active && $stable(trial)));
    // R4: the step counter never passes the latch step
    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (sar_q.step <= STEP_W'(BAND_W)));
    // R4: the latch tick ends the search
    assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);
    // R5: the trial code only changes on a tick or a trigger
    assert_tick_paced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(trial));
endmodule

// File: rtl/vbc_result.sv
module vbc_result #(
    parameter int unsigned BAND_W  = vbc_pkg::VBC_BAND_W,
    parameter int unsigned DIV_W   = vbc_pkg::VBC_DIV_W,
    parameter int unsigned DIV_MAX = vbc_pkg::VBC_DIV_MAX,
    parameter int unsigned AMP_W   = vbc_pkg::VBC_AMP_W,
    parameter int unsigned DATA_W  = vbc_pkg::VBC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    input  logic [BAND_W-1:0] trial,
    input  logic [DATA_W-1:0] div_cfg,
    output logic [BAND_W-1:0] band_res,
    output logic [DIV_W-1:0]  div_code,
    output logic [AMP_W-1:0]  amp_code
);
    localparam logic [AMP_W-1:0] AMP_MID = {1'b1, {(AMP_W-1){1'b0}}};

    typedef struct packed {
        logic [DIV_W-1:0]  div_snap;
        logic [BAND_W-1:0] band;
        logic [DIV_W-1:0]  div;
        logic [AMP_W-1:0]  amp;
    } res_t;

    res_t res_d, res_q;
    logic [DIV_W-1:0] div_clamped;

    always_comb begin
        res_d       = res_q;
        div_clamped = (div_cfg > DATA_W'(DIV_MAX)) ? DIV_W'(DIV_MAX)
                                                   : div_cfg[DIV_W-1:0];
        if (start)
            res_d.div_snap = div_clamped;
        if (done) begin
            res_d.band = trial;
            res_d.div  = res_q.div_snap;
            res_d.amp  = AMP_MID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign band_res = res_q.band;
    assign div_code = res_q.div;
    assign amp_code = res_q.amp;

    // R6: amplitude lands on midscale with every latched result
    assert_amp_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> amp_code == AMP_MID);
    // R10: results only move on the latch tick
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(band_res) && $stable(div_code) && $stable(amp_code)));
    // R7: the divider never leaves its legal range
    assert_div_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> div_code <= DIV_W'(DIV_MAX));
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
    parameter int unsigned ADDR_W    = vbc_pkg::VBC_ADDR_W,
    parameter int unsigned DATA_W    = vbc_pkg::VBC_DATA_W,
    parameter int unsigned BAND_W    = vbc_pkg::VBC_BAND_W,
    parameter int unsigned DIV_W     = vbc_pkg::VBC_DIV_W,
    parameter int unsigned DIV_MAX   = vbc_pkg::VBC_DIV_MAX,
    parameter int unsigned AMP_W     = vbc_pkg::VBC_AMP_W,
    parameter int unsigned TRIG_ADDR = 3,
    parameter int unsigned DIV_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pfd_tick,
    input  logic              fb_fast,
    output logic [BAND_W-1:0] band_code,
    output logic [DIV_W-1:0]  div_code,
    output logic [AMP_W-1:0]  amp_code,
    output logic              tune_park,
    output logic              busy
);
    logic              trig;
    logic              active;
    logic              done;
    logic [BAND_W-1:0] trial;
    logic [BAND_W-1:0] band_res;
    logic [DATA_W-1:0] div_cfg;

    vbc_cfg_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .TRIG_ADDR(TRIG_ADDR), .DIV_ADDR(DIV_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig(trig), .div_cfg(div_cfg)
    );

    vbc_sar #(.BAND_W(BAND_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(trig), .tick(pfd_tick),
        .fb_fast(fb_fast), .active(active), .done(done), .trial(trial)
    );

    vbc_result #(
        .BAND_W(BAND_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX),
        .AMP_W(AMP_W), .DATA_W(DATA_W)
    ) u_res (
        .clk(clk), .rst_n(rst_n), .start(trig), .done(done), .trial(trial),
        .div_cfg(div_cfg), .band_res(band_res), .div_code(div_code),
        .amp_code(amp_code)
    );

    // The oscillator sees the trial code while searching, the result otherwise
    assign band_code = active ? trial : band_res;
    assign tune_park = active;
    assign busy      = active;

    // R3: a write elsewhere never starts a search from idle
    assert_other_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_addr != ADDR_W'(TRIG_ADDR)) |=> !busy);
    // R2: a trigger write always leaves the tuning node parked
    assert_trig_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(TRIG_ADDR)) |=> (busy && tune_park));
    // R10: while idle the band output is the held result
    assert_idle_band_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> $stable(band_code));
endmodule

// File: tb/vco_band_cal_tb.sv
module vco_band_cal_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pfd_tick = 1'b0;
    logic       fb_fast;
    logic [3:0] band_code, div_code, amp_code;
    logic       tune_park, busy;

    int  errors = 0;
    int  checks = 0;
    int  tgt = 0;
    bit  tick_en = 1'b0;
    bit  finished = 1'b0;
    int  tcnt = 0;

    always #4 clk = ~clk;

    // Oscillator model: feedback is faster when the band exceeds the target
    assign fb_fast = (int'(band_code) > tgt);

    // PFD tick every 4 clocks, driven after the edge
    always @(posedge clk) begin
        tcnt     <= (tcnt == 3) ? 0 : tcnt + 1;
        pfd_tick <= tick_en && (tcnt == 3);
    end

    vco_band_cal u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pfd_tick(pfd_tick), .fb_fast(fb_fast),
        .band_code(band_code), .div_code(div_code), .amp_code(amp_code),
        .tune_park(tune_park), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait at negedges until n ticks are consumed while busy; returns count
    task automatic run_ticks(input int n, output int seen, output int park_bad);
        seen = 0; park_bad = 0;
        for (int i = 0; i < 400 && busy && seen < n; i++) begin
            if (tune_park != busy) park_bad++;
            if (pfd_tick) seen++;
            @(negedge clk);
        end
    endtask

    task automatic full_cal(input int t, input logic [7:0] dv, input int exp_div);
        int seen, pb;
        tgt = t;
        wr(2'd1, dv);
        wr(2'd3, 8'h00);
        chk("R2 busy after trigger", busy, 1);
        chk("R2 park after trigger", tune_park, 1);
        chk("R2 first trial", band_code, 8);
        run_ticks(100, seen, pb);
        chk("R4 ticks per calibration", seen, 5);
        chk("R4 park tracks busy", pb, 0);
        chk("R4 done", busy, 0);
        chk("R5 band result", band_code, t);
        chk("R6 amp midscale", amp_code, 8);
        chk("R7 div code", div_code, exp_div);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 park", tune_park, 0);
        chk("R1 band", band_code, 0);
        chk("R1 div", div_code, 0);
        chk("R1 amp", amp_code, 0);
    endtask

    task automatic t_other_addr();
        wr(2'd0, 8'h55);
        wr(2'd2, 8'hAA);
        wr(2'd1, 8'h04);
        repeat (10) @(negedge clk);
        chk("R3 no start", busy, 0);
        chk("R3 band idle", band_code, 0);
        chk("R3 div untouched", div_code, 0);
    endtask

    task automatic t_search();
        full_cal(5, 8'd7, 7);
        full_cal(15, 8'd0, 0);
        full_cal(0, 8'd12, 12);
        full_cal(10, 8'hFF, 12);   // R7 clamp above 12
        full_cal(13, 8'd13, 12);   // R7 clamp just above limit
    endtask

    task automatic t_mid_write();
        int seen, pb;
        wr(2'd1, 8'd9);
        tgt = 6;
        wr(2'd3, 8'h00);
        run_ticks(2, seen, pb);
        wr(2'd1, 8'd3);
        run_ticks(100, seen, pb);
        chk("R9 mid-cal write ignored", div_code, 9);
        chk("R9 band", band_code, 6);
        wr(2'd3, 8'h00);
        run_ticks(100, seen, pb);
        chk("R9 next trigger uses new value", div_code, 3);
    endtask

    task automatic t_restart();
        int seen, pb;
        tgt = 2;
        wr(2'd3, 8'h00);
        run_ticks(2, seen, pb);
        chk("R8 two ticks before restart", seen, 2);
        tgt = 11;
        wr(2'd3, 8'h00);
        chk("R8 busy after restart", busy, 1);
        chk("R8 trial reset", band_code, 8);
        run_ticks(100, seen, pb);
        chk("R8 five ticks after restart", seen, 5);
        chk("R8 result from restarted search", band_code, 11);
    endtask

    task automatic t_idle_hold();
        logic [3:0] b0, d0, a0;
        int bad = 0;
        b0 = band_code; d0 = div_code; a0 = amp_code;
        for (int i = 0; i < 40; i++) begin
            tgt = (i % 2 == 0) ? 0 : 15;
            @(negedge clk);
            if (band_code != b0 || div_code != d0 || amp_code != a0 || busy) bad++;
        end
        chk("R10 R11 idle outputs held", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        tick_en = 1'b1;
        t_other_addr();
        t_search();
        t_mid_write();
        t_restart();
        t_idle_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule